// File: doc/BRIEF.md
# SPI Hold Pause Front End

This block sits between the pins of a mode 0/3 SPI slave and its shift engine, and all of its logic runs on an oversampling system clock. It resynchronises chip select, serial clock, serial data in and the hold input. It turns serial clock edges into one-cycle enable pulses for the shift engine and gates those pulses with a pause state that the hold input controls. The host can then freeze a transfer partway through and resume it later, and the shift engine keeps its bit and byte position because it sees no edges during the pause.

Entry into and exit from the pause is qualified by the serial clock level. A hold change made while the serial clock is low acts at once. A change made while the clock is high waits for the next falling clock edge, and that falling edge is not passed on. The output-enable for the serial data-out pin is separate from this. It tracks the hold input directly and drops or returns as soon as hold changes, whatever the clock level. Raising chip select ends the sequence and clears any pause.

Top module: `spi_hold_frontend`

## Requirements
- R1: Chip select, serial clock, serial data in and hold each pass through a two-flop synchroniser, and every output is registered. A pin change made between two system clock edges appears at a level output after the third rising system clock edge and not after the second.
- R2: While chip select is low (selected) and the block is not paused, each rising serial clock edge gives exactly one one-cycle pulse on `shift_rise_o` and each falling edge gives exactly one one-cycle pulse on `shift_fall_o`.
- R3: Hold low (active) while serial clock is low sets the pause (`paused_o` = 1). Hold low while serial clock is high leaves `paused_o` at 0 until the next falling serial clock edge, which sets the pause and gives no `shift_fall_o` pulse.
- R4: Hold high while serial clock is low clears the pause. Hold high while serial clock is high keeps `paused_o` at 1 until the next falling serial clock edge, which clears it and gives no `shift_fall_o` pulse.
- R5: While paused, serial clock and serial data in transitions give no shift pulses. After resume, the pulses that follow add to those that came before, so a transfer broken by a pause gives the same total count of rising and falling pulses as an unbroken one.
- R6: `so_oe_o` is 1 exactly when chip select is low and hold is high, whatever the serial clock level and the pause state.
- R7: Chip select high clears the pause, blocks both shift pulses and holds `so_oe_o` at 0.
- R8: `so_o` is a copy of `core_so_i` taken one system clock later, and `si_o` is the synchronised serial data in.
- R9: After reset, with chip select and hold pins high, all outputs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (oversampling) clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Chip select pin, low selects |
| sck_i | input | 1 | Serial clock pin |
| si_i | input | 1 | Serial data in pin |
| hold_n_i | input | 1 | Hold pin, low requests a pause |
| core_so_i | input | 1 | Data-out bit from the shift engine (system clock domain) |
| shift_rise_o | output | 1 | One-cycle pulse for a qualified rising serial clock edge |
| shift_fall_o | output | 1 | One-cycle pulse for a qualified falling serial clock edge |
| si_o | output | 1 | Synchronised serial data in |
| paused_o | output | 1 | Pause state |
| so_oe_o | output | 1 | Output-enable for the data-out pin driver |
| so_o | output | 1 | Data for the data-out pin driver |

## Verification
The assertions check on every cycle that the pause is only entered with the synchronised clock and hold both low, and only left on deselect or with hold high and clock low. They also check that deselection clears it, that edge pulses last one cycle and never coincide, and that a low hold turns the output driver off on the following cycle. The bench scenarios show what no single-cycle property can: that an edge deferred across a high clock phase is swallowed and not forwarded, and that a pause placed at any bit position of a byte leaves the total pulse count unchanged. They also show the three-cycle pin-to-output latency and the full-cycle timing of the data-out copy.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
  localparam int PIN_W = 4;

  typedef struct packed {
    logic cs_n;
    logic sck;
    logic si;
    logic hold_n;
  } pin_vec_t;

  localparam pin_vec_t PIN_IDLE = '{cs_n: 1'b1, sck: 1'b0, si: 1'b0, hold_n: 1'b1};
endpackage

// File: rtl/spi_hold_sync.sv
module spi_hold_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int LAST = STAGES - 1;

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= RST_VAL;
    else     stg[0] <= d_i;
  end

  genvar gi;
  generate
    for (gi = 1; gi < STAGES; gi++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[gi] <= RST_VAL;
        else     stg[gi] <= stg[gi-1];
      end
    end
  endgenerate

  assign q_o = stg[LAST];
endmodule

// File: rtl/spi_hold_edge.sv
module spi_hold_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
  assign fall_o = ~lvl_i & lvl_q;

  a_r2_edges_disjoint: assert property (@(posedge clk) disable iff (rst)
    !(rise_o && fall_o));
  a_r2_rise_one_cycle: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);
  a_r2_fall_one_cycle: assert property (@(posedge clk) disable iff (rst)
    fall_o |=> !fall_o);
endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic cs_n_i,
  input  logic sck_i,
  input  logic hold_n_i,
  input  logic rise_i,
  input  logic fall_i,
  output logic paused_o,
  output logic rise_ok_o,
  output logic fall_ok_o
);
  logic paused_q;
  logic paused_d;

  // Pause entry/exit only while the synchronised clock is low; a hold
  // change seen with the clock high is thereby deferred to the next fall.
  always_comb begin
    paused_d = paused_q;
    if (cs_n_i)                          paused_d = 1'b0;
    else if (!paused_q && !hold_n_i && !sck_i) paused_d = 1'b1;
    else if (paused_q && hold_n_i && !sck_i)   paused_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) paused_q <= 1'b0;
    else     paused_q <= paused_d;
  end

  assign paused_o  = paused_q;
  assign rise_ok_o = rise_i & ~cs_n_i & ~paused_q;
  // A fall that coincides with a pending pause is the entry point: swallow it.
  assign fall_ok_o = fall_i & ~cs_n_i & ~paused_q & hold_n_i;

  a_r3_enter_low_sck: assert property (@(posedge clk) disable iff (rst)
    $rose(paused_q) |-> $past(!sck_i && !hold_n_i && !cs_n_i));
  a_r4_leave_low_sck: assert property (@(posedge clk) disable iff (rst)
    $fell(paused_q) |-> $past(cs_n_i || (hold_n_i && !sck_i)));
  a_r7_deselect_clears: assert property (@(posedge clk) disable iff (rst)
    cs_n_i |=> !paused_q);
endmodule

// File: rtl/spi_hold_frontend.sv
module spi_hold_frontend
  import spi_hold_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n_i,
  input  logic sck_i,
  input  logic si_i,
  input  logic hold_n_i,
  input  logic core_so_i,
  output logic shift_rise_o,
  output logic shift_fall_o,
  output logic si_o,
  output logic paused_o,
  output logic so_oe_o,
  output logic so_o
);
  pin_vec_t pins_raw;
  pin_vec_t pins_s;
  logic     rise_w, fall_w;
  logic     rise_ok_w, fall_ok_w;
  logic     paused_w;

  assign pins_raw = '{cs_n: cs_n_i, sck: sck_i, si: si_i, hold_n: hold_n_i};

  spi_hold_sync #(
    .WIDTH   (PIN_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (PIN_IDLE)
  ) sync_i (
    .clk (clk),
    .rst (rst),
    .d_i (pins_raw),
    .q_o (pins_s)
  );

  spi_hold_edge edge_i (
    .clk    (clk),
    .rst    (rst),
    .lvl_i  (pins_s.sck),
    .rise_o (rise_w),
    .fall_o (fall_w)
  );

  spi_hold_ctrl ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .cs_n_i    (pins_s.cs_n),
    .sck_i     (pins_s.sck),
    .hold_n_i  (pins_s.hold_n),
    .rise_i    (rise_w),
    .fall_i    (fall_w),
    .paused_o  (paused_w),
    .rise_ok_o (rise_ok_w),
    .fall_ok_o (fall_ok_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_rise_o <= 1'b0;
      shift_fall_o <= 1'b0;
      si_o         <= 1'b0;
      paused_o     <= 1'b0;
      so_oe_o      <= 1'b0;
      so_o         <= 1'b0;
    end else begin
      shift_rise_o <= rise_ok_w;
      shift_fall_o <= fall_ok_w;
      si_o         <= pins_s.si;
      paused_o     <= paused_w;
      so_oe_o      <= ~pins_s.cs_n & pins_s.hold_n;
      so_o         <= core_so_i;
    end
  end

  a_r6_hold_drops_oe: assert property (@(posedge clk) disable iff (rst)
    !pins_s.hold_n |=> !so_oe_o);
  a_r7_deselect_no_pulse: assert property (@(posedge clk) disable iff (rst)
    pins_s.cs_n |=> !shift_rise_o && !shift_fall_o);
  a_r5_paused_no_pulse: assert property (@(posedge clk) disable iff (rst)
    paused_w |=> !shift_rise_o && !shift_fall_o);
endmodule

// File: tb/spi_hold_frontend_tb_top.sv
`timescale 1ns/1ps
module spi_hold_frontend_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, core_so = 1'b0;
  logic shift_rise, shift_fall, si_s, paused, so_oe, so_d;

  int n_chk = 0, n_err = 0;
  int rise_cnt = 0, fall_cnt = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  spi_hold_frontend dut_i (
    .clk (clk), .rst (rst),
    .cs_n_i (cs_n), .sck_i (sck), .si_i (si), .hold_n_i (hold_n),
    .core_so_i (core_so),
    .shift_rise_o (shift_rise), .shift_fall_o (shift_fall),
    .si_o (si_s), .paused_o (paused), .so_oe_o (so_oe), .so_o (so_d)
  );

  always @(negedge clk) begin
    cyc++;
    if (!rst && shift_rise) rise_cnt++;
    if (!rst && shift_fall) fall_cnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sck_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      si = ~si; sck = 1'b1; w(4);
      sck = 1'b0; w(4);
    end
  endtask

  int r0, f0;

  initial begin
    w(3);
    rst = 1'b0;
    w(1);
    // R9 reset state
    chk({shift_rise, shift_fall, si_s, paused, so_oe, so_d} == 6'b0, "R9 outputs after reset",
        {shift_rise, shift_fall, si_s, paused, so_oe, so_d}, 0);

    // R1 latency: select, check after 2 and after 3 rising clock edges
    cs_n = 1'b0;
    w(2);
    chk(so_oe == 1'b0, "R1 oe not yet after two edges", so_oe, 0);
    w(1);
    chk(so_oe == 1'b1, "R1/R6 oe after three edges", so_oe, 1);

    // R2 plain transfer
    r0 = rise_cnt; f0 = fall_cnt;
    sck_cycles(8); w(4);
    chk(rise_cnt - r0 == 8, "R2 rise pulses", rise_cnt - r0, 8);
    chk(fall_cnt - f0 == 8, "R2 fall pulses", fall_cnt - f0, 8);

    // R8 data-out copy and synchronised SI
    core_so = 1'b1; w(1);
    chk(so_d == 1'b1, "R8 so follows core", so_d, 1);
    core_so = 1'b0; w(1);
    chk(so_d == 1'b0, "R8 so follows core low", so_d, 0);
    si = 1'b1; w(4);
    chk(si_s == 1'b1, "R8 si synchronised", si_s, 1);

    // R3 pause with SCK low, R5 ignored clocks, R4 resume with SCK low
    hold_n = 1'b0; w(6);
    chk(paused == 1'b1, "R3 pause with sck low", paused, 1);
    chk(so_oe == 1'b0, "R6 oe off while hold low", so_oe, 0);
    r0 = rise_cnt; f0 = fall_cnt;
    sck_cycles(3); w(2);
    chk(rise_cnt == r0 && fall_cnt == f0, "R5 no pulses while paused", rise_cnt - r0 + fall_cnt - f0, 0);
    hold_n = 1'b1; w(6);
    chk(paused == 1'b0, "R4 resume with sck low", paused, 0);
    chk(so_oe == 1'b1, "R6 oe back on", so_oe, 1);

    // R3 deferred entry: hold falls while SCK high
    f0 = fall_cnt;
    sck = 1'b1; w(4);
    hold_n = 1'b0; w(5);
    chk(paused == 1'b0, "R3 no pause while sck high", paused, 0);
    chk(so_oe == 1'b0, "R6 oe drops regardless of sck", so_oe, 0);
    sck = 1'b0; w(5);
    chk(paused == 1'b1, "R3 pause at next fall", paused, 1);
    chk(fall_cnt == f0, "R3 entry fall swallowed", fall_cnt - f0, 0);

    // R4 deferred exit: hold rises while SCK high
    r0 = rise_cnt;
    sck = 1'b1; w(4);
    hold_n = 1'b1; w(5);
    chk(paused == 1'b1, "R4 still paused while sck high", paused, 1);
    chk(so_oe == 1'b1, "R6 oe returns regardless of sck", so_oe, 1);
    sck = 1'b0; w(5);
    chk(paused == 1'b0, "R4 resume at next fall", paused, 0);
    chk(fall_cnt == f0 && rise_cnt == r0, "R4 exit edges swallowed",
        fall_cnt - f0 + rise_cnt - r0, 0);
    r0 = rise_cnt; f0 = fall_cnt;
    sck_cycles(4); w(4);
    chk(rise_cnt - r0 == 4 && fall_cnt - f0 == 4, "R2 pulses after resume", rise_cnt - r0, 4);

    // R7 deselect clears a pause
    hold_n = 1'b0; w(6);
    chk(paused == 1'b1, "R7 paused before deselect", paused, 1);
    cs_n = 1'b1; w(6);
    chk(paused == 1'b0, "R7 deselect clears pause", paused, 0);
    hold_n = 1'b1; w(6);
    chk(so_oe == 1'b0, "R7 oe off while deselected", so_oe, 0);
    r0 = rise_cnt; f0 = fall_cnt;
    sck_cycles(3); w(4);
    chk(rise_cnt == r0 && fall_cnt == f0, "R7 no pulses while deselected",
        rise_cnt - r0 + fall_cnt - f0, 0);

    // R5 sweep: pause at every bit position of a byte
    for (int n = 0; n <= 8; n++) begin
      cs_n = 1'b0; w(4);
      r0 = rise_cnt; f0 = fall_cnt;
      sck_cycles(n);
      hold_n = 1'b0; w(6);
      sck_cycles(2);
      hold_n = 1'b1; w(6);
      sck_cycles(8 - n); w(4);
      chk(rise_cnt - r0 == 8, $sformatf("R5 rise total, pause at bit %0d", n), rise_cnt - r0, 8);
      chk(fall_cnt - f0 == 8, $sformatf("R5 fall total, pause at bit %0d", n), fall_cnt - f0, 8);
      cs_n = 1'b1; w(6);
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    wait (cyc >= 20000);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule